// File: doc/BRIEF.md
# Asynchronous Serial Port with Hardware Flow Control

This block is a full-duplex asynchronous serial port. A host loads one character at a time into a single-entry transmit holding register and reads received characters from a single-entry receive holding register. Configuration comes in on plain inputs: the baud divisor, the character length, the parity mode, a fixed parity value and the stop length. All timing runs from one baud tick at sixteen times the bit rate. The transmitter counts its stop interval in these ticks, so the stop length can be set in sixteenths of a bit.

The receiver oversamples the line. It sees a start bit at a falling edge, checks it again at mid-bit and then samples each following bit at its centre. It flags parity errors, framing errors and overruns on separate outputs. Flow control needs no software. The ready-to-send output tells the far end to pause while a received character waits to be read. The transmitter does not begin a character while the clear-to-send input is low.

Top module: `uart_core`

## Requirements
- R1: `cfg_len` selects the character length: 0, 1, 2 and 3 give 5, 6, 7 and 8 data bits. Data travels least significant bit first in both directions, and received characters are zero-extended on `rx_data`.
- R2: A frame is a low start bit, the data bits, an optional parity bit and a high stop interval. `cfg_par` selects the parity bit: 0 none, 1 even (data plus parity holds an even number of ones), 2 odd, 3 fixed to the value of `cfg_par_val`.
- R3: When parity is enabled, the receiver sets `rx_perr` with the character if the received parity bit differs from the bit that R2 gives for the received data. It leaves `rx_perr` clear otherwise.
- R4: The stop interval lasts `cfg_stop` baud ticks, and values below 16 are treated as 16. When a second character is waiting, its start bit follows the stop interval with no gap, so consecutive start edges are (16·(1+data bits+parity bits) + stop ticks) ticks apart.
- R5: One baud tick occurs every `cfg_div` clock cycles, and every start, data and parity bit lasts 16 ticks.
- R6: The receiver samples a falling edge again 8 ticks later. If the line is back high by then, it discards the edge and delivers no character.
- R7: A low level at the stop-bit sample sets `rx_ferr`, and the character is still delivered to `rx_data`.
- R8: If a character completes while `rx_valid` is high and `rx_rd` is not asserted, the block sets `rx_ovr`, discards the new character and keeps `rx_data` unchanged. `rx_rd` clears `rx_valid`, `rx_perr`, `rx_ferr` and `rx_ovr`.
- R9: `rts` is low exactly while the receive holding register is full (`rx_valid` high).
- R10: The transmitter starts a character only on a tick where `cts` is high. `tx_ready` drops in the cycle after an accepted `tx_wr` and rises again once that character has started.
- R11: After reset `txd` and `rts` are high, `tx_ready` is high, and `rx_valid` and all error flags are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_div | input | DIV_W | Clock cycles per baud tick |
| cfg_len | input | 2 | Character length code |
| cfg_par | input | 2 | Parity mode code |
| cfg_par_val | input | 1 | Parity bit value in fixed mode |
| cfg_stop | input | STOP_W | Stop interval in baud ticks |
| tx_wr | input | 1 | Load `tx_data` into the transmit holding register |
| tx_data | input | 8 | Character to send |
| tx_ready | output | 1 | Transmit holding register is empty |
| rx_rd | input | 1 | Acknowledge and release the received character |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | Receive holding register is full |
| rx_perr | output | 1 | Parity error on the held character |
| rx_ferr | output | 1 | Framing error on the held character |
| rx_ovr | output | 1 | A character was lost to overrun |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| cts | input | 1 | Far end is ready to receive |
| rts | output | 1 | This end is ready to receive |

## Verification
The bench builds the block with DIV_W=8, STOP_W=6 and SYNC_STAGES=2, and mostly runs a divisor of 4, so one bit lasts 64 clocks. That short bit keeps every character short, and a single run covers all four lengths and all four parity modes. The 6-bit stop field reaches stop intervals of 24 and 37 ticks, where fractional stop lengths change the exact spacing of start edges, and a value of 5 tests the clamp to 16 ticks. One spacing run at a divisor of 3 checks that the tick rate follows the configured divisor.

// File: rtl/uart_pkg.sv
package uart_pkg;

   typedef enum logic [1:0] {
      PAR_NONE  = 2'd0,
      PAR_EVEN  = 2'd1,
      PAR_ODD   = 2'd2,
      PAR_FIXED = 2'd3
   } par_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } frame_st_e;

   localparam int unsigned TICKS_PER_BIT = 16;
   localparam int unsigned MID_TICK      = 8;

   function automatic logic [3:0] char_bits(input logic [1:0] len);
      return 4'd5 + {2'b00, len};
   endfunction

   function automatic logic calc_par(input par_mode_e mode, input logic [7:0] d,
                                     input logic [1:0] len, input logic fixed);
      logic [7:0] mask;
      logic       x;
      mask = 8'hFF >> (2'd3 - len);
      x    = ^(d & mask);
      case (mode)
         PAR_EVEN:  return x;
         PAR_ODD:   return ~x;
         PAR_FIXED: return fixed;
         default:   return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
   parameter int unsigned DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] cfg_div,
   output logic             tick
);
   if (DIV_W < 1) begin : g_bad_div
      $error("uart_baud: DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] lim;

   assign lim  = (cfg_div == '0) ? '0 : cfg_div - 1'b1;
   assign tick = (cnt >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

   // R5: with a divisor above one, ticks never come on adjacent clocks
   p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && lim != '0) |=> !tick);

endmodule

// File: rtl/uart_tx.sv
module uart_tx
   import uart_pkg::*;
#(
   parameter int unsigned STOP_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [1:0]        cfg_len,
   input  par_mode_e         cfg_par,
   input  logic              cfg_par_val,
   input  logic [STOP_W-1:0] cfg_stop,
   input  logic              tx_wr,
   input  logic [7:0]        tx_data,
   output logic              tx_ready,
   input  logic              cts,
   output logic              txd
);
   if (STOP_W < 5) begin : g_bad_stop
      $error("uart_tx: STOP_W must hold at least 16");
   end

   localparam logic [STOP_W-1:0] MIN_STOP = STOP_W'(TICKS_PER_BIT);
   localparam logic [3:0]        LAST_T   = 4'(TICKS_PER_BIT - 1);

   frame_st_e         st;
   logic [3:0]        tcnt;
   logic [2:0]        bidx;
   logic [7:0]        sh;
   logic              pbit;
   logic [STOP_W-1:0] scnt;
   logic [STOP_W-1:0] stop_len;
   logic              pend;
   logic [7:0]        hold;
   logic [3:0]        nb;
   logic              stop_end;
   logic              go;

   assign nb       = char_bits(cfg_len);
   assign stop_len = (cfg_stop < MIN_STOP) ? MIN_STOP : cfg_stop;
   assign stop_end = (st == ST_STOP) && (scnt == stop_len - 1'b1);
   assign go       = tick && pend && cts && ((st == ST_IDLE) || stop_end);
   assign tx_ready = !pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         tcnt <= '0;
         bidx <= '0;
         sh   <= '0;
         pbit <= 1'b0;
         scnt <= '0;
         pend <= 1'b0;
         hold <= '0;
         txd  <= 1'b1;
      end else begin
         if (tx_wr && !pend) begin
            pend <= 1'b1;
            hold <= tx_data;
         end
         if (go) begin
            st   <= ST_START;
            txd  <= 1'b0;
            tcnt <= '0;
            sh   <= hold;
            pbit <= calc_par(cfg_par, hold, cfg_len, cfg_par_val);
            pend <= 1'b0;
         end else if (tick) begin
            case (st)
               ST_START: begin
                  if (tcnt == LAST_T) begin
                     st   <= ST_DATA;
                     tcnt <= '0;
                     bidx <= '0;
                     txd  <= sh[0];
                  end else tcnt <= tcnt + 1'b1;
               end
               ST_DATA: begin
                  if (tcnt == LAST_T) begin
                     tcnt <= '0;
                     if ({1'b0, bidx} == nb - 4'd1) begin
                        if (cfg_par != PAR_NONE) begin
                           st  <= ST_PAR;
                           txd <= pbit;
                        end else begin
                           st   <= ST_STOP;
                           txd  <= 1'b1;
                           scnt <= '0;
                        end
                     end else begin
                        bidx <= bidx + 1'b1;
                        sh   <= sh >> 1;
                        txd  <= sh[1];
                     end
                  end else tcnt <= tcnt + 1'b1;
               end
               ST_PAR: begin
                  if (tcnt == LAST_T) begin
                     st   <= ST_STOP;
                     tcnt <= '0;
                     txd  <= 1'b1;
                     scnt <= '0;
                  end else tcnt <= tcnt + 1'b1;
               end
               ST_STOP: begin
                  if (stop_end) st <= ST_IDLE;
                  else          scnt <= scnt + 1'b1;
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   // R10: a start edge on the line only follows a clock where cts was high
   p_start_needs_cts_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(txd) |-> $past(cts));
   // R10: an accepted write fills the holding register
   p_write_fills_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && tx_ready) |=> !tx_ready);
   // R4: the line stays high for the whole stop interval
   p_stop_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STOP) |-> txd);

endmodule

// File: rtl/uart_rx.sv
module uart_rx
   import uart_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic [1:0] cfg_len,
   input  par_mode_e  cfg_par,
   input  logic       cfg_par_val,
   input  logic       rxd,
   input  logic       rx_rd,
   output logic [7:0] rx_data,
   output logic       rx_valid,
   output logic       rx_perr,
   output logic       rx_ferr,
   output logic       rx_ovr
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("uart_rx: SYNC_STAGES must be at least 2");
   end

   localparam logic [3:0] LAST_T = 4'(TICKS_PER_BIT - 1);
   localparam logic [3:0] CONF_T = 4'(MID_TICK - 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   s;
   logic                   prev;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q[0] <= 1'b1;
            else        sync_q[0] <= rxd;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q[i] <= 1'b1;
            else        sync_q[i] <= sync_q[i-1];
      end
   end
   assign s = sync_q[SYNC_STAGES-1];

   frame_st_e  st;
   logic [3:0] cnt;
   logic [2:0] bidx;
   logic [7:0] sh;
   logic       pbit_rx;
   logic [3:0] nb;
   logic [7:0] word;
   logic       done;

   assign nb   = char_bits(cfg_len);
   assign word = sh >> (4'd8 - nb);
   assign done = tick && (st == ST_STOP) && (cnt == LAST_T);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         bidx    <= '0;
         sh      <= '0;
         pbit_rx <= 1'b0;
         prev    <= 1'b1;
      end else begin
         prev <= s;
         case (st)
            ST_IDLE: begin
               if (prev && !s) begin
                  st  <= ST_START;
                  cnt <= '0;
               end
            end
            ST_START: if (tick) begin
               if (cnt == CONF_T) begin
                  cnt  <= '0;
                  bidx <= '0;
                  st   <= s ? ST_IDLE : ST_DATA;
               end else cnt <= cnt + 1'b1;
            end
            ST_DATA: if (tick) begin
               if (cnt == LAST_T) begin
                  cnt <= '0;
                  sh  <= {s, sh[7:1]};
                  if ({1'b0, bidx} == nb - 4'd1)
                     st <= (cfg_par != PAR_NONE) ? ST_PAR : ST_STOP;
                  else
                     bidx <= bidx + 1'b1;
               end else cnt <= cnt + 1'b1;
            end
            ST_PAR: if (tick) begin
               if (cnt == LAST_T) begin
                  cnt     <= '0;
                  pbit_rx <= s;
                  st      <= ST_STOP;
               end else cnt <= cnt + 1'b1;
            end
            ST_STOP: if (tick) begin
               if (cnt == LAST_T) st <= ST_IDLE;
               else               cnt <= cnt + 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // one-deep holding register with error flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data  <= '0;
         rx_valid <= 1'b0;
         rx_perr  <= 1'b0;
         rx_ferr  <= 1'b0;
         rx_ovr   <= 1'b0;
      end else begin
         if (rx_rd) begin
            rx_valid <= 1'b0;
            rx_perr  <= 1'b0;
            rx_ferr  <= 1'b0;
            rx_ovr   <= 1'b0;
         end
         if (done) begin
            if (rx_valid && !rx_rd) begin
               rx_ovr <= 1'b1;
            end else begin
               rx_data  <= word;
               rx_valid <= 1'b1;
               rx_perr  <= (cfg_par != PAR_NONE) &&
                           (pbit_rx != calc_par(cfg_par, word, cfg_len, cfg_par_val));
               rx_ferr  <= !s;
            end
         end
      end
   end

   // R7: error flags only ever describe a held character
   p_err_with_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_perr || rx_ferr) |-> rx_valid);
   // R8: an unread character is never overwritten
   p_hold_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_rd) |=> (rx_valid && $stable(rx_data)));
   // R8: overrun only arises while a character is held
   p_ovr_on_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ovr) |-> rx_valid);

endmodule

// File: rtl/uart_core.sv
module uart_core
   import uart_pkg::*;
#(
   parameter int unsigned DIV_W       = 12,
   parameter int unsigned STOP_W      = 6,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic [1:0]        cfg_len,
   input  logic [1:0]        cfg_par,
   input  logic              cfg_par_val,
   input  logic [STOP_W-1:0] cfg_stop,
   input  logic              tx_wr,
   input  logic [7:0]        tx_data,
   output logic              tx_ready,
   input  logic              rx_rd,
   output logic [7:0]        rx_data,
   output logic              rx_valid,
   output logic              rx_perr,
   output logic              rx_ferr,
   output logic              rx_ovr,
   output logic              txd,
   input  logic              rxd,
   input  logic              cts,
   output logic              rts
);
   logic      tick;
   par_mode_e par_mode;

   assign par_mode = par_mode_e'(cfg_par);

   uart_baud #(.DIV_W(DIV_W)) u_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_div (cfg_div),
      .tick    (tick)
   );

   uart_tx #(.STOP_W(STOP_W)) u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .cfg_len     (cfg_len),
      .cfg_par     (par_mode),
      .cfg_par_val (cfg_par_val),
      .cfg_stop    (cfg_stop),
      .tx_wr       (tx_wr),
      .tx_data     (tx_data),
      .tx_ready    (tx_ready),
      .cts         (cts),
      .txd         (txd)
   );

   uart_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .cfg_len     (cfg_len),
      .cfg_par     (par_mode),
      .cfg_par_val (cfg_par_val),
      .rxd         (rxd),
      .rx_rd       (rx_rd),
      .rx_data     (rx_data),
      .rx_valid    (rx_valid),
      .rx_perr     (rx_perr),
      .rx_ferr     (rx_ferr),
      .rx_ovr      (rx_ovr)
   );

   assign rts = !rx_valid;

   // R9: a full holding register is released only by a read
   p_rts_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!rts && !rx_rd) |=> !rts);

endmodule

// File: tb/test_uart_core.sv
`timescale 1ns/1ps
module test_uart_core;
   localparam int DIV_W = 8;
   localparam int STOP_W = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [DIV_W-1:0]  cfg_div = 8'd4;
   logic [1:0]        cfg_len = 2'd3;
   logic [1:0]        cfg_par = 2'd0;
   logic              cfg_par_val = 1'b0;
   logic [STOP_W-1:0] cfg_stop = 6'd16;
   logic tx_wr = 1'b0;
   logic [7:0] tx_data = '0;
   logic tx_ready;
   logic rx_rd = 1'b0;
   logic [7:0] rx_data;
   logic rx_valid, rx_perr, rx_ferr, rx_ovr;
   logic txd;
   logic rxd = 1'b1;
   logic cts = 1'b1;
   logic rts;

   int  vectors = 0;
   int  errors = 0;
   longint cyc = 0;
   int  bitclk = 64;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   uart_core #(.DIV_W(DIV_W), .STOP_W(STOP_W), .SYNC_STAGES(2)) i_uart_core (
      .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_len(cfg_len),
      .cfg_par(cfg_par), .cfg_par_val(cfg_par_val), .cfg_stop(cfg_stop),
      .tx_wr(tx_wr), .tx_data(tx_data), .tx_ready(tx_ready), .rx_rd(rx_rd),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr),
      .rx_ferr(rx_ferr), .rx_ovr(rx_ovr), .txd(txd), .rxd(rxd),
      .cts(cts), .rts(rts));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // per-clock model of the ready-to-send line (R9)
   always @(negedge clk) if (rst_n) chk("R9 rts vs holding", rts, !rx_valid);

   function automatic logic ref_par(input logic [7:0] d, input int n, input int mode, input logic fx);
      int ones = $countones(d & ((1 << n) - 1));
      case (mode)
         1: return (ones % 2) == 1;
         2: return (ones % 2) == 0;
         3: return fx;
         default: return 1'b0;
      endcase
   endfunction

   function automatic int frame_bits();
      return 1 + (cfg_len + 5) + (cfg_par != 0 ? 1 : 0) + 1;
   endfunction

   function automatic logic [11:0] ref_frame(input logic [7:0] d);
      logic [11:0] f = '1;
      int n = cfg_len + 5;
      f[0] = 1'b0;
      for (int k = 0; k < n; k++) f[1+k] = d[k];
      if (cfg_par != 0) f[1+n] = ref_par(d, n, cfg_par, cfg_par_val);
      return f;
   endfunction

   task automatic tx_write(input logic [7:0] d);
      while (!tx_ready) @(negedge clk);
      tx_data = d; tx_wr = 1'b1;
      @(negedge clk);
      tx_wr = 1'b0;
   endtask

   task automatic tx_capture(output logic [11:0] bits, output longint t0);
      int nb = frame_bits();
      bits = '1;
      while (txd !== 1'b0) @(negedge clk);
      t0 = cyc;
      repeat (bitclk/2) @(negedge clk);
      bits[0] = txd;
      for (int k = 1; k < nb; k++) begin
         repeat (bitclk) @(negedge clk);
         bits[k] = txd;
      end
   endtask

   task automatic tx_char(input string req, input logic [7:0] d);
      logic [11:0] got; longint t;
      fork
         tx_write(d);
         tx_capture(got, t);
      join
      chk(req, got, ref_frame(d));
   endtask

   task automatic tx_pair(input string req, input logic [7:0] a, input logic [7:0] b, input int stop_eff);
      logic [11:0] g1, g2; longint t1, t2; int exp;
      fork
         begin tx_write(a); tx_write(b); end
         begin tx_capture(g1, t1); tx_capture(g2, t2); end
      join
      exp = (16 * (frame_bits() - 1) + stop_eff) * cfg_div;
      chk({req, " spacing"}, 32'(t2 - t1), exp);
      chk({req, " frame2"}, g2, ref_frame(b));
   endtask

   task automatic rx_send(input logic [7:0] d, input bit bad_par, input bit stop_low);
      int n = cfg_len + 5;
      rxd = 1'b0; repeat (bitclk) @(negedge clk);
      for (int k = 0; k < n; k++) begin rxd = d[k]; repeat (bitclk) @(negedge clk); end
      if (cfg_par != 0) begin
         rxd = ref_par(d, n, cfg_par, cfg_par_val) ^ bad_par;
         repeat (bitclk) @(negedge clk);
      end
      if (stop_low) begin rxd = 1'b0; repeat (bitclk) @(negedge clk); end
      rxd = 1'b1; repeat (bitclk) @(negedge clk);
   endtask

   task automatic rx_expect(input string req, input logic [7:0] d, input bit pe, input bit fe, input bit ov);
      chk({req, " valid"}, rx_valid, 1'b1);
      chk({req, " data"}, rx_data, d & ((1 << (cfg_len + 5)) - 1));
      chk({req, " perr"}, rx_perr, pe);
      chk({req, " ferr"}, rx_ferr, fe);
      chk({req, " ovr"}, rx_ovr, ov);
      rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0; @(negedge clk);
      chk({req, " cleared"}, {rx_valid, rx_perr, rx_ferr, rx_ovr}, 4'b0000);
   endtask

   task automatic cfg(input int len, input int par, input logic pv, input int stop);
      cfg_len = 2'(len); cfg_par = 2'(par); cfg_par_val = pv; cfg_stop = 6'(stop);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 reset outputs", {txd, rts, tx_ready, rx_valid, rx_perr, rx_ferr, rx_ovr}, 7'b1110000);

      // R1 R2 R5 transmit frames
      cfg(3, 0, 0, 16); tx_char("R1 tx 8N", 8'hA5);
      cfg(0, 1, 0, 16); tx_char("R2 tx 5 even", 8'h13);
      cfg(2, 2, 0, 16); tx_char("R2 tx 7 odd", 8'h5B);
      cfg(1, 3, 1, 16); tx_char("R2 tx 6 fixed1", 8'h2C);
      cfg(1, 3, 0, 16); tx_char("R2 tx 6 fixed0", 8'h3F);

      // R4 stop lengths in sixteenths, and clamp
      cfg(3, 2, 0, 24); tx_pair("R4 stop24", 8'h81, 8'h7E, 24);
      cfg(3, 0, 0, 37); tx_pair("R4 stop37", 8'h11, 8'hEE, 37);
      cfg(0, 0, 0, 5);  tx_pair("R4 stop clamp", 8'h0A, 8'h15, 16);

      // R5 different divisor
      cfg_div = 8'd3; bitclk = 48;
      cfg(3, 0, 0, 16); tx_pair("R5 div3", 8'h3C, 8'hC3, 16);
      cfg_div = 8'd4; bitclk = 64;

      // R10 cts holds the transmitter
      cts = 1'b0;
      cfg(3, 0, 0, 16);
      tx_write(8'h69);
      chk("R10 ready drops", tx_ready, 1'b0);
      begin
         int lows = 0;
         repeat (3000) begin @(negedge clk); if (txd !== 1'b1) lows++; end
         chk("R10 no start without cts", lows, 0);
      end
      begin
         logic [11:0] got; longint t;
         fork
            begin repeat (5) @(negedge clk); cts = 1'b1; end
            tx_capture(got, t);
         join
         chk("R10 frame after cts", got, ref_frame(8'h69));
         chk("R10 ready after start", tx_ready, 1'b1);
      end

      // R1 R3 receive, good parity in each mode
      cfg(3, 0, 0, 16); rx_send(8'hC5, 0, 0); rx_expect("R1 rx 8N", 8'hC5, 0, 0, 0);
      cfg(0, 1, 0, 16); rx_send(8'h1D, 0, 0); rx_expect("R1 rx 5 even", 8'h1D, 0, 0, 0);
      cfg(2, 2, 0, 16); rx_send(8'h4E, 0, 0); rx_expect("R3 rx 7 odd ok", 8'h4E, 0, 0, 0);
      cfg(1, 3, 1, 16); rx_send(8'h25, 0, 0); rx_expect("R3 rx fixed ok", 8'h25, 0, 0, 0);
      // R3 parity errors
      cfg(1, 3, 1, 16); rx_send(8'h25, 1, 0); rx_expect("R3 rx fixed bad", 8'h25, 1, 0, 0);
      cfg(3, 1, 0, 16); rx_send(8'h96, 1, 0); rx_expect("R3 rx even bad", 8'h96, 1, 0, 0);
      // R7 framing error
      cfg(3, 0, 0, 16); rx_send(8'h5A, 0, 1); rx_expect("R7 rx framing", 8'h5A, 0, 1, 0);

      // R8 R9 overrun
      cfg(3, 0, 0, 16);
      rx_send(8'h31, 0, 0);
      chk("R9 rts low when full", rts, 1'b0);
      rx_send(8'hF0, 0, 0);
      rx_expect("R8 overrun keeps first", 8'h31, 0, 0, 1);
      chk("R9 rts high after read", rts, 1'b1);

      // R6 short low glitch ignored
      rxd = 1'b0; repeat (10) @(negedge clk); rxd = 1'b1;
      repeat (3 * bitclk) @(negedge clk);
      chk("R6 glitch ignored", rx_valid, 1'b0);
      rx_send(8'h77, 0, 0); rx_expect("R6 rx after glitch", 8'h77, 0, 0, 0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule